// File: doc/BRIEF.md
# Reference-Bit Victim Selector

This block decides which way of a cache set is evicted when a new block has to be brought in. It does not keep a full recency ordering. Instead it holds one "referenced" flag per way. Any access to a way sets that way's flag. A free-running interval timer wipes every flag at a fixed period, so a flag that is set means the way was touched in the current interval.

When the cache asks for a replacement, the selector returns a way index one cycle later, together with a one-cycle valid pulse. The choice is made in this order:

- The lowest-indexed way that holds no valid data.
- Otherwise, the lowest-indexed way whose flag is clear.
- Otherwise, when every valid way has been touched, a round-robin pointer, which then moves on by one.

Tag compare, data storage and line fill belong to the surrounding cache.

Top module: `refbit_replacer`

## Requirements
- R1: Each way has exactly one referenced flag. An access strobe with a way index sets that way's flag at the next clock edge, and a set way is not chosen while any valid way with a clear flag exists.
- R2: An interval counter starts at 0 after reset and counts to CLEAR_PERIOD-1 (default 30). In the cycle where the counter reaches CLEAR_PERIOD-1, every flag is cleared at the clock edge that ends that cycle. A request made in that cycle still sees the flags as they were before the clear.
- R3: When an access and the periodic clear fall in the same cycle, the accessed way's flag ends up set and all other flags end up clear.
- R4: When every way is valid and some flags are clear, the victim is the lowest-indexed way whose flag is clear.
- R5: A way whose `blkValid` bit is 0 is chosen ahead of every valid way. Among such ways, the lowest index wins.
- R6: When every way is valid and every flag is set, the victim is the round-robin pointer's value. The pointer then advances by one, wrapping from NUM_WAYS-1 to 0. The pointer does not move on any other request.
- R7: The selection uses the flags as they stood before any access in the same cycle. `victimIdx` and `victimValid` are registered and appear in the cycle after `replReq`. `victimValid` is 1 for exactly one cycle per request and is 0 otherwise.
- R8: A synchronous active-high `rst` clears all flags, the interval counter and the round-robin pointer, and holds `victimValid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accValid | input | 1 | An access touches way `accIdx` this cycle |
| accIdx | input | IDX_W | Index of the accessed way |
| blkValid | input | NUM_WAYS | Per-way valid bit; bit i is 1 when way i holds data |
| replReq | input | 1 | Request for a victim way |
| victimIdx | output | IDX_W | Chosen way, registered |
| victimValid | output | 1 | One-cycle pulse, in the cycle after `replReq` |

## Verification
The bench issues a request in the very cycle of the periodic clear and again in the cycle after it. A design that clears one cycle early or late returns the wrong way in one of those two cycles. It lines an access up with the clear, which catches a design that lets the clear win over the access. It asks repeatedly with every flag set, which exposes a pointer that does not wrap or that moves on a non-fallback request. It also marks ways invalid while flags are set, to catch a priority that puts clear flags ahead of empty ways. Finally, it combines a request with an access in one cycle, and resets in the middle of a run to show that the pointer returns to 0.

// File: rtl/refbit_pkg.sv
package refbit_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic wipe;     // clear all referenced flags at this edge
    logic capture;  // register a victim choice
    logic advance;  // step the round-robin pointer
  } repl_strobe_t;
endpackage

// File: rtl/repl_ctrl.sv
module repl_ctrl
  import refbit_pkg::*;
#(
  parameter int NUM_WAYS     = 8,
  parameter int CLEAR_PERIOD = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                replReq,
  input  logic [NUM_WAYS-1:0] blkValid,
  input  logic [NUM_WAYS-1:0] refState,
  output repl_strobe_t        strb
);
  localparam int CNT_W = $clog2(CLEAR_PERIOD + 1);

  logic [CNT_W-1:0] tickCnt;
  logic             lastTick;
  logic             allTouched;

  assign lastTick   = (tickCnt == CNT_W'(CLEAR_PERIOD - 1));
  assign allTouched = &(refState & blkValid);

  always_ff @(posedge clk) begin
    if (rst)           tickCnt <= '0;
    else if (lastTick) tickCnt <= '0;
    else               tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    strb.wipe    = lastTick;
    strb.capture = replReq;
    strb.advance = replReq & allTouched;
  end
endmodule

// File: rtl/repl_datapath.sv
module repl_datapath
  import refbit_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accValid,
  input  logic [IDX_W-1:0]    accIdx,
  input  logic [NUM_WAYS-1:0] blkValid,
  input  repl_strobe_t        strb,
  output logic [NUM_WAYS-1:0] refState,
  output logic [IDX_W-1:0]    rrPtr,
  output logic [IDX_W-1:0]    victimIdx,
  output logic                victimValid
);
  logic [NUM_WAYS-1:0] accMask;
  logic [NUM_WAYS-1:0] refNext;
  logic                freeHit, coldHit;
  logic [IDX_W-1:0]    freeIdx, coldIdx, pick, rrNext;

  always_comb begin
    accMask = '0;
    if (accValid) accMask[accIdx] = 1'b1;
    refNext = strb.wipe ? accMask : (refState | accMask);
  end

  // Lowest-index search: scan downward so the smallest index is kept
  always_comb begin
    freeHit = 1'b0;
    freeIdx = '0;
    coldHit = 1'b0;
    coldIdx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!blkValid[i]) begin
        freeHit = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (!refState[i]) begin
        coldHit = 1'b1;
        coldIdx = IDX_W'(i);
      end
    end
    if (freeHit)      pick = freeIdx;
    else if (coldHit) pick = coldIdx;
    else              pick = rrPtr;
    rrNext = (rrPtr == IDX_W'(NUM_WAYS - 1)) ? '0 : rrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refState    <= '0;
      rrPtr       <= '0;
      victimIdx   <= '0;
      victimValid <= 1'b0;
    end else begin
      refState    <= refNext;
      victimValid <= strb.capture;
      if (strb.capture) victimIdx <= pick;
      if (strb.advance) rrPtr <= rrNext;
    end
  end
endmodule

// File: rtl/refbit_replacer.sv
module refbit_replacer
  import refbit_pkg::*;
#(
  parameter int NUM_WAYS     = 8,
  parameter int CLEAR_PERIOD = 30,
  localparam int IDX_W       = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accValid,
  input  logic [IDX_W-1:0]    accIdx,
  input  logic [NUM_WAYS-1:0] blkValid,
  input  logic                replReq,
  output logic [IDX_W-1:0]    victimIdx,
  output logic                victimValid
);
  repl_strobe_t        strb;
  logic [NUM_WAYS-1:0] refState;
  logic [IDX_W-1:0]    rrPtr;

  repl_ctrl #(.NUM_WAYS(NUM_WAYS), .CLEAR_PERIOD(CLEAR_PERIOD)) u_ctrl (
    .clk(clk), .rst(rst), .replReq(replReq), .blkValid(blkValid),
    .refState(refState), .strb(strb)
  );

  repl_datapath #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .accValid(accValid), .accIdx(accIdx),
    .blkValid(blkValid), .strb(strb), .refState(refState), .rrPtr(rrPtr),
    .victimIdx(victimIdx), .victimValid(victimValid)
  );
endmodule

// File: rtl/refbit_replacer_chk.sv
module refbit_replacer_chk #(
  parameter int NUM_WAYS     = 8,
  parameter int CLEAR_PERIOD = 30,
  parameter int IDX_W        = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                accValid,
  input logic [IDX_W-1:0]    accIdx,
  input logic [NUM_WAYS-1:0] blkValid,
  input logic                replReq,
  input logic [IDX_W-1:0]    victimIdx,
  input logic                victimValid,
  input logic [NUM_WAYS-1:0] refState,
  input logic [IDX_W-1:0]    rrPtr,
  input logic                wipe,
  input logic                advance
);
  localparam int GAP_W = $clog2(CLEAR_PERIOD + 1);
  logic [GAP_W-1:0] gap;

  // Cycles since the last clear, kept independently of the control counter
  always_ff @(posedge clk) begin
    if (rst || wipe) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  p_period_r2: assert property (@(posedge clk) disable iff (rst)
    wipe |-> gap == GAP_W'(CLEAR_PERIOD - 1));

  p_wipe_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (wipe && !accValid) |=> refState == '0);

  p_access_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (wipe && accValid) |=> refState == (NUM_WAYS'(1) << $past(accIdx)));

  p_access_sets_r1: assert property (@(posedge clk) disable iff (rst)
    accValid |=> |(refState & (NUM_WAYS'(1) << $past(accIdx))));

  p_invalid_first_r5: assert property (@(posedge clk) disable iff (rst)
    (replReq && !(&blkValid)) |=> !(|($past(blkValid) & (NUM_WAYS'(1) << victimIdx))));

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    replReq |=> victimValid);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    !replReq |=> !victimValid);

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(rrPtr));
endmodule

bind refbit_replacer refbit_replacer_chk #(
  .NUM_WAYS(NUM_WAYS), .CLEAR_PERIOD(CLEAR_PERIOD), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .accValid(accValid), .accIdx(accIdx),
  .blkValid(blkValid), .replReq(replReq), .victimIdx(victimIdx),
  .victimValid(victimValid), .refState(refState), .rrPtr(rrPtr),
  .wipe(strb.wipe), .advance(strb.advance)
);

// File: tb/sim_refbit_replacer.sv
`timescale 1ns/1ps
module sim_refbit_replacer;
  localparam int N  = 8;
  localparam int P  = 30;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst;
  logic          accValid;
  logic [IW-1:0] accIdx;
  logic [N-1:0]  blkValid;
  logic          replReq;
  logic [IW-1:0] victimIdx;
  logic          victimValid;

  always #2 clk = ~clk;  // 250 MHz

  refbit_replacer #(.NUM_WAYS(N), .CLEAR_PERIOD(P)) u0 (
    .clk(clk), .rst(rst), .accValid(accValid), .accIdx(accIdx),
    .blkValid(blkValid), .replReq(replReq), .victimIdx(victimIdx),
    .victimValid(victimValid)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;
  int    expQ[$];
  string tagQ[$];

  // Reference model state, built from the requirements
  bit [N-1:0] refM;
  int         rrM;
  int         mcnt;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // One cycle of stimulus, entered and left at a falling edge
  task automatic step(bit a, int idx, bit r, string tag);
    bit wipe;
    int e;
    accValid = a;
    accIdx   = IW'(idx);
    replReq  = r;
    if (r) begin
      e = -1;
      for (int i = N - 1; i >= 0; i--) if (!blkValid[i]) e = i;
      if (e < 0) for (int i = N - 1; i >= 0; i--) if (!refM[i]) e = i;
      if (e < 0) begin
        e   = rrM;
        rrM = (rrM + 1) % N;
      end
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    wipe = (mcnt == P - 1);
    if (wipe) refM = '0;
    if (a) refM[idx] = 1'b1;
    mcnt = wipe ? 0 : mcnt + 1;
    @(negedge clk);
    accValid = 1'b0;
    replReq  = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    accValid = 1'b0;
    replReq  = 1'b0;
    repeat (3) @(negedge clk);
    nChecks++;
    if (victimValid !== 1'b0) begin
      nFails++;
      $display("FAIL R8 victimValid in reset act=%b exp=0", victimValid);
    end
    rst  = 1'b0;
    refM = '0;
    rrM  = 0;
    mcnt = 0;
  endtask

  // Monitor: compare results one cycle after each request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (expQ.size() > 0) begin
          int    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          nChecks++;
          if (victimValid !== 1'b1 || int'(victimIdx) != e) begin
            nFails++;
            $display("FAIL %s victim act=%0d/v%b exp=%0d/v1", t, victimIdx, victimValid, e);
          end
        end else if (victimValid !== 1'b0) begin
          nChecks++;
          nFails++;
          $display("FAIL R7 spurious victimValid act=%b exp=0", victimValid);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end

  initial begin
    blkValid = '1;
    accIdx   = '0;
    @(negedge clk);
    doReset();
    step(0, 0, 1, "R8 flags clear after reset");
    for (int i = 0; i < 3; i++) step(1, i, 0, "");
    step(0, 0, 1, "R4 lowest clear flag");
    for (int i = 3; i < N; i++) step(1, i, 0, "");
    step(0, 0, 1, "R1 R6 fallback first");
    step(0, 0, 1, "R6 fallback second");
    step(0, 0, 1, "R6 fallback third");
    blkValid[5] = 1'b0;
    blkValid[6] = 1'b0;
    step(0, 0, 1, "R5 invalid way first");
    blkValid[5] = 1'b1;
    step(0, 0, 1, "R5 next invalid way");
    blkValid = '1;
    step(0, 0, 1, "R6 pointer held by non-fallback");
    // access coinciding with the clear
    while (mcnt != P - 1) step(0, 0, 0, "");
    step(1, 0, 0, "");
    step(0, 0, 1, "R3 access kept over clear");
    step(1, 1, 0, "");
    step(0, 0, 1, "R2 others cleared");
    // exact period: request in the clear cycle sees old flags
    for (int i = 0; i < N; i++) step(1, i, 0, "");
    while (mcnt != P - 1) step(0, 0, 0, "");
    step(0, 0, 1, "R2 flags still set in clear cycle");
    step(0, 0, 1, "R2 flags cleared after period");
    step(1, 0, 1, "R7 same-cycle access not seen");
    step(0, 0, 1, "R7 access seen next cycle");
    for (int i = 0; i < N; i++) step(1, i, 0, "");
    for (int i = 0; i < N + 1; i++) step(0, 0, 1, "R6 pointer wrap");
    // reset in mid-run returns pointer to 0
    for (int i = 0; i < 3; i++) step(1, i, 0, "");
    doReset();
    for (int i = 0; i < N; i++) step(1, i, 0, "");
    step(0, 0, 1, "R8 pointer reset");
    repeat (3) @(negedge clk);
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R7 missing results act=%0d exp=0", expQ.size());
    end
    report();
  end
endmodule